// File: doc/BRIEF.md
# Interrupt Controller Command-Word Sequencer

This block is the processor-facing register front end of an eight-input programmable interrupt controller. A byte-wide data bus reaches it through two ports, which one address bit selects. Separate write and read strobes qualify each access. After reset, software must program the controller with a short series of initialization words. The first word is always written to port 0. The words that follow go to port 1, and their number depends on two flag bits in the first word. A five-state sequencer tracks how far this series has progressed.

Once the series is complete, port 1 writes load the eight-bit interrupt mask. Port 0 writes are decoded into one of two operation words, distinguished by data bits 4:3. The first kind can request an end of interrupt. The block turns that request into a one-cycle pulse with a specific/non-specific flag and a three-bit level, which the neighbouring in-service logic consumes. The second kind chooses which register a port 0 read returns.

The block drives the vector base, the automatic-EOI and x86 mode flags, and the mask to the rest of the controller. It also multiplexes the request, in-service and mask registers onto the read bus. The request and in-service registers themselves are held elsewhere and come in as inputs.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the sequencer waits for the first initialization word. `ready` is 0. The mask, vector base, `auto_eoi` and `x86_mode` are all 0. The port 0 read selection points at the request register.
- R2: While waiting for the first word, port 1 writes and port 0 writes with data bit 4 clear have no effect. The mask stays 0 and `ready` stays 0.
- R3: A port 0 write with data bit 4 set is a first initialization word in every state. It moves to the wait-for-vector state, clears the mask, `auto_eoi` and `x86_mode`, and drops `ready`. It also captures bit 0 (fourth word needed) and bit 1 (single controller).
- R4: In the wait-for-vector state, a port 1 write loads `vec_base`. If the single bit is 1 and the fourth-word bit is 0, the block becomes ready next.
- R5: When the single bit is 0, the port 1 write after the vector is taken as a cascade word. It changes neither the mask nor the vector. The block then waits for the fourth word if bit 0 was set, and otherwise becomes ready.
- R6: The fourth word, written to port 1, sets `auto_eoi` from data bit 1 and `x86_mode` from data bit 0. The block then becomes ready.
- R7: When ready, a port 1 write loads the mask (`mask_out`) with the written byte.
- R8: When ready, a port 0 write with bits 4:3 = 00, bit 5 = 1 and bit 7 = 0 raises `eoi_pulse` for exactly the next cycle. In that cycle `eoi_specific` equals bit 6 and `eoi_level` equals bits 2:0. If bit 5 = 0 or bit 7 = 1, no pulse is produced. When there is no pulse, `eoi_specific` and `eoi_level` are 0.
- R9: When ready, a port 0 write with bits 4:3 = 01 and bit 1 = 1 sets the read selection from bit 0 (1 = in-service, 0 = request). If bit 1 = 0, the selection keeps its previous value.
- R10: With `rd_en` high, `rdata` returns the selected request or in-service byte for port 0, and the mask for port 1. With `rd_en` low, `rdata` is 0.
- R11: During the vector, cascade and fourth-word waits, port 0 writes with bit 4 clear are ignored. They do not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Port select: 0 = command port, 1 = data port |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| irr_in | input | 8 | Request register from the priority block |
| isr_in | input | 8 | In-service register from the priority block |
| rdata | output | 8 | Read data |
| mask_out | output | 8 | Interrupt mask register |
| vec_base | output | 8 | Vector base from the second initialization word |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| x86_mode | output | 1 | x86 processor mode |
| ready | output | 1 | Initialization complete |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt command |
| eoi_specific | output | 1 | End of interrupt names a level |
| eoi_level | output | 3 | Level for a specific end of interrupt |

## Verification
The hardest state to reach is the cascade-word wait. It exists only when the first word has the single bit clear, and in that state a port 1 write must not touch the mask or the vector. The stimulus re-initializes the block from the ready state with several flag combinations: cascade plus fourth word, cascade without it, and single without the fourth word. After each port 1 write it checks the vector, the mask and `ready`. Stray port 0 writes are also placed between the initialization words, to show that they do not advance the sequence.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int PIC_DW    = 8;
    localparam int PIC_LVL_W = $clog2(PIC_DW);

    typedef enum logic [2:0] {
        ST_WAIT_ICW1 = 3'd0,
        ST_WAIT_ICW2 = 3'd1,
        ST_WAIT_ICW3 = 3'd2,
        ST_WAIT_ICW4 = 3'd3,
        ST_READY     = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e             st;
        logic                   need_icw4;
        logic                   single;
        logic [PIC_DW-1:0]      vec;
        logic [PIC_DW-1:0]      mask;
        logic                   auto_eoi;
        logic                   x86;
        logic                   sel_isr;
        logic                   eoi_pulse;
        logic                   eoi_spec;
        logic [PIC_LVL_W-1:0]   eoi_lvl;
    } seq_regs_t;

endpackage

// File: rtl/pic_cw_decode.sv
module pic_cw_decode (
    input  logic       wr_en,
    input  logic       addr,
    input  logic [1:0] kind_bits,
    output logic       is_init,
    output logic       is_opw_eoi,
    output logic       is_opw_rdsel,
    output logic       is_port1
);
    always_comb begin
        is_init      = wr_en && !addr && kind_bits[1];
        is_opw_eoi   = wr_en && !addr && (kind_bits == 2'b00);
        is_opw_rdsel = wr_en && !addr && (kind_bits == 2'b01);
        is_port1     = wr_en && addr;
    end
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux #(
    parameter int DW = 8
) (
    input  logic          rd_en,
    input  logic          addr,
    input  logic          sel_isr,
    input  logic [DW-1:0] irr,
    input  logic [DW-1:0] isr,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] rdata
);
    always_comb begin
        if (!rd_en)
            rdata = '0;
        else if (addr)
            rdata = mask;
        else if (sel_isr)
            rdata = isr;
        else
            rdata = irr;
    end
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
    import pic_cmd_pkg::*;
#(
    parameter int DW    = PIC_DW,
    parameter int LVL_W = PIC_LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    irr_in,
    input  logic [DW-1:0]    isr_in,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    mask_out,
    output logic [DW-1:0]    vec_base,
    output logic             auto_eoi,
    output logic             x86_mode,
    output logic             ready,
    output logic             eoi_pulse,
    output logic             eoi_specific,
    output logic [LVL_W-1:0] eoi_level
);
    localparam int BIT_IC4   = 0;
    localparam int BIT_SNGL  = 1;
    localparam int BIT_EOI   = 5;
    localparam int BIT_SL    = 6;
    localparam int BIT_ROT   = 7;
    localparam int BIT_RDEN  = 1;
    localparam int BIT_RDISR = 0;

    seq_regs_t regs_d, regs_q;

    logic is_init, is_opw_eoi, is_opw_rdsel, is_port1;

    pic_cw_decode u_dec (
        .wr_en        (wr_en),
        .addr         (addr),
        .kind_bits    (wdata[4:3]),
        .is_init      (is_init),
        .is_opw_eoi   (is_opw_eoi),
        .is_opw_rdsel (is_opw_rdsel),
        .is_port1     (is_port1)
    );

    pic_rd_mux #(.DW(DW)) u_rd (
        .rd_en   (rd_en),
        .addr    (addr),
        .sel_isr (regs_q.sel_isr),
        .irr     (irr_in),
        .isr     (isr_in),
        .mask    (regs_q.mask),
        .rdata   (rdata)
    );

    always_comb begin
        regs_d           = regs_q;
        regs_d.eoi_pulse = 1'b0;
        regs_d.eoi_spec  = 1'b0;
        regs_d.eoi_lvl   = '0;
        if (is_init) begin
            regs_d.st        = ST_WAIT_ICW2;
            regs_d.need_icw4 = wdata[BIT_IC4];
            regs_d.single    = wdata[BIT_SNGL];
            regs_d.mask      = '0;
            regs_d.auto_eoi  = 1'b0;
            regs_d.x86       = 1'b0;
        end else if (is_port1) begin
            case (regs_q.st)
                ST_WAIT_ICW2: begin
                    regs_d.vec = wdata;
                    if (!regs_q.single)
                        regs_d.st = ST_WAIT_ICW3;
                    else if (regs_q.need_icw4)
                        regs_d.st = ST_WAIT_ICW4;
                    else
                        regs_d.st = ST_READY;
                end
                ST_WAIT_ICW3: begin
                    regs_d.st = regs_q.need_icw4 ? ST_WAIT_ICW4 : ST_READY;
                end
                ST_WAIT_ICW4: begin
                    regs_d.auto_eoi = wdata[1];
                    regs_d.x86      = wdata[0];
                    regs_d.st       = ST_READY;
                end
                ST_READY: begin
                    regs_d.mask = wdata;
                end
                default: ;
            endcase
        end else if (regs_q.st == ST_READY) begin
            if (is_opw_eoi && wdata[BIT_EOI] && !wdata[BIT_ROT]) begin
                regs_d.eoi_pulse = 1'b1;
                regs_d.eoi_spec  = wdata[BIT_SL];
                regs_d.eoi_lvl   = wdata[LVL_W-1:0];
            end else if (is_opw_rdsel && wdata[BIT_RDEN]) begin
                regs_d.sel_isr = wdata[BIT_RDISR];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_WAIT_ICW1, default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mask_out     = regs_q.mask;
    assign vec_base     = regs_q.vec;
    assign auto_eoi     = regs_q.auto_eoi;
    assign x86_mode     = regs_q.x86;
    assign ready        = (regs_q.st == ST_READY);
    assign eoi_pulse    = regs_q.eoi_pulse;
    assign eoi_specific = regs_q.eoi_spec;
    assign eoi_level    = regs_q.eoi_lvl;

endmodule

// File: rtl/pic_cmd_seq_chk.sv
module pic_cmd_seq_chk #(
    parameter int DW    = 8,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic [DW-1:0]    wdata,
    input logic [DW-1:0]    rdata,
    input logic [DW-1:0]    mask_out,
    input logic [DW-1:0]    vec_base,
    input logic             ready,
    input logic             eoi_pulse,
    input logic             eoi_specific,
    input logic [LVL_W-1:0] eoi_level
);
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (mask_out == '0 && !ready)); // R3

    AST_EOI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse |-> $past(wr_en && !addr && ready && wdata[4:3] == 2'b00
                            && wdata[5] && !wdata[7])); // R8

    AST_EOI_QUIET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_pulse |-> (!eoi_specific && eoi_level == '0)); // R8

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_out)); // R7

    AST_VEC_HOLD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(wr_en && !addr && wdata[4])) |=> $stable(vec_base)); // R4

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0); // R10
endmodule

bind pic_cmd_seq pic_cmd_seq_chk #(.DW(DW), .LVL_W(LVL_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .wdata        (wdata),
    .rdata        (rdata),
    .mask_out     (mask_out),
    .vec_base     (vec_base),
    .ready        (ready),
    .eoi_pulse    (eoi_pulse),
    .eoi_specific (eoi_specific),
    .eoi_level    (eoi_level)
);

// File: tb/test_pic_cmd_seq.sv
module test_pic_cmd_seq;
    localparam int OBS_RDATA = 0;
    localparam int OBS_MASK  = 1;
    localparam int OBS_VEC   = 2;
    localparam int OBS_EOI   = 3;
    localparam int OBS_MODE  = 4;
    localparam logic [7:0] IRR_VAL = 8'hA5;
    localparam logic [7:0] ISR_VAL = 8'h3C;

    typedef struct {
        string      req;
        int         obs;
        logic [7:0] exp;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] irr_in = IRR_VAL;
    logic [7:0] isr_in = ISR_VAL;
    logic [7:0] rdata, mask_out, vec_base;
    logic       auto_eoi, x86_mode, ready, eoi_pulse, eoi_specific;
    logic [2:0] eoi_level;

    exp_item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pic_cmd_seq i_pic_cmd_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .wdata        (wdata),
        .irr_in       (irr_in),
        .isr_in       (isr_in),
        .rdata        (rdata),
        .mask_out     (mask_out),
        .vec_base     (vec_base),
        .auto_eoi     (auto_eoi),
        .x86_mode     (x86_mode),
        .ready        (ready),
        .eoi_pulse    (eoi_pulse),
        .eoi_specific (eoi_specific),
        .eoi_level    (eoi_level)
    );

    function automatic logic [7:0] observe(int obs);
        case (obs)
            OBS_RDATA: return rdata;
            OBS_MASK:  return mask_out;
            OBS_VEC:   return vec_base;
            OBS_EOI:   return {3'b000, eoi_pulse, eoi_specific, eoi_level};
            default:   return {5'b00000, ready, auto_eoi, x86_mode};
        endcase
    endfunction

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = observe(it.obs);
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s obs=%0d actual=%02h expected=%02h", it.req, it.obs, act, it.exp);
            end
        end
    end

    task automatic push(string req, int obs, logic [7:0] exp);
        exp_item_t it;
        it.req = req;
        it.obs = obs;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        #1;
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(string req, logic a, logic en, logic [7:0] exp);
        addr  = a;
        rd_en = en;
        push(req, OBS_RDATA, exp);
        @(negedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    // mode byte = {ready, auto_eoi, x86_mode}
    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        push("R1", OBS_MASK, 8'h00);
        push("R1", OBS_VEC, 8'h00);
        push("R1", OBS_MODE, 8'h00);
        push("R1", OBS_EOI, 8'h00);
        rd("R1", 1'b0, 1'b1, IRR_VAL);

        // R2: writes before the first word are ignored
        wr(1'b1, 8'hFF);
        wr(1'b0, 8'h20);
        push("R2", OBS_MASK, 8'h00);
        push("R2", OBS_MODE, 8'h00);
        push("R2", OBS_EOI, 8'h00);

        // R3/R4/R6/R11: single, fourth word required
        wr(1'b0, 8'h13);
        push("R3", OBS_MODE, 8'h00);
        wr(1'b1, 8'h40);
        push("R4", OBS_VEC, 8'h40);
        push("R4", OBS_MODE, 8'h00);
        wr(1'b0, 8'h0A);
        push("R11", OBS_MODE, 8'h00);
        wr(1'b1, 8'h03);
        push("R6", OBS_MODE, 8'h07);
        push("R6", OBS_VEC, 8'h40);
        push("R11", OBS_MASK, 8'h00);

        // R7/R10: mask load and read-back
        wr(1'b1, 8'h5A);
        push("R7", OBS_MASK, 8'h5A);
        rd("R10", 1'b1, 1'b1, 8'h5A);
        rd("R10", 1'b0, 1'b0, 8'h00);

        // R8: end-of-interrupt decoding
        wr(1'b0, 8'h63);
        push("R8", OBS_EOI, 8'h1B);
        idle();
        push("R8", OBS_EOI, 8'h00);
        wr(1'b0, 8'h20);
        push("R8", OBS_EOI, 8'h10);
        wr(1'b0, 8'hA0);
        push("R8", OBS_EOI, 8'h00);
        wr(1'b0, 8'h47);
        push("R8", OBS_EOI, 8'h00);
        push("R8", OBS_MASK, 8'h5A);

        // R9: read selection
        wr(1'b0, 8'h0B);
        rd("R9", 1'b0, 1'b1, ISR_VAL);
        wr(1'b0, 8'h08);
        rd("R9", 1'b0, 1'b1, ISR_VAL);
        wr(1'b0, 8'h0A);
        rd("R9", 1'b0, 1'b1, IRR_VAL);

        // R3/R5: re-init from ready, cascade word then fourth word
        wr(1'b0, 8'h11);
        push("R3", OBS_MASK, 8'h00);
        push("R3", OBS_MODE, 8'h00);
        wr(1'b1, 8'h88);
        push("R5", OBS_VEC, 8'h88);
        push("R5", OBS_MODE, 8'h00);
        wr(1'b1, 8'h04);
        push("R5", OBS_VEC, 8'h88);
        push("R5", OBS_MASK, 8'h00);
        push("R5", OBS_MODE, 8'h00);
        wr(1'b1, 8'h02);
        push("R6", OBS_MODE, 8'h06);

        // R3/R4: single, no fourth word; flags cleared
        wr(1'b0, 8'h12);
        push("R3", OBS_MODE, 8'h00);
        wr(1'b1, 8'h20);
        push("R4", OBS_VEC, 8'h20);
        push("R4", OBS_MODE, 8'h04);

        // R5: cascade without fourth word
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h30);
        push("R5", OBS_MODE, 8'h00);
        wr(1'b1, 8'h01);
        push("R5", OBS_MODE, 8'h04);
        push("R5", OBS_VEC, 8'h30);
        push("R5", OBS_MASK, 8'h00);
        rd("R9", 1'b0, 1'b1, IRR_VAL);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog req=all actual=timeout expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule